// File: doc/BRIEF.md
# Masked Vector Ternary Logic Unit

This block evaluates an arbitrary three-input Boolean function across three wide vector operands in one pass. An 8-bit function code is read as a truth table. For every bit position the three operand bits form an index, and the output bit is the code bit at that index. Any of the 256 possible functions of three inputs can be chosen this way, including XOR, majority, bit select, AND, OR, NOR and the two constants.

The computed vector is then written lane by lane under a write mask. A lane-size input splits the vector into either 64-bit lanes or 32-bit lanes. Each mask bit enables the lane with the same index. A lane whose mask bit is clear is either forced to zero or filled from a pass-through operand, as chosen by a mode input. The result is captured in an output register, and the output valid flag trails the input valid flag by one clock.

Top module: `tvl_top`

## Requirements
- R1: For each bit position i, the output bit is func_code[{opd_a[i], opd_b[i], opd_c[i]}]. In that 3-bit index, opd_a is bit 2 and opd_c is bit 0.
- R2: Code 0x96 yields a^b^c, 0xE8 yields the majority of a, b and c, 0xCA yields a ? b : c, and 0x80 yields a&b&c.
- R3: Code 0x00 yields all zeros, 0xFF yields all ones, 0xFE yields a|b|c, and 0x01 yields ~(a|b|c).
- R4: With lane_wide=1 the vector holds 8 lanes of 64 bits. Lane N (bits 64N+63..64N) is governed by lane_mask[N], and lane_mask[15:8] has no effect.
- R5: With lane_wide=0 the vector holds 16 lanes of 32 bits. Lane N (bits 32N+31..32N) is governed by lane_mask[N].
- R6: A lane whose mask bit is 0 reads as zero when merge_en=0.
- R7: A lane whose mask bit is 0 takes the same bits of pass_src when merge_en=1.
- R8: When every mask bit in use is 1, the output equals the unmasked function result for either value of merge_en.
- R9: out_valid is in_valid delayed by one clock. out_data shows, one clock later, the result for the inputs present while in_valid=1, and holds its value while in_valid=0.
- R10: While reset is active, out_valid=0 and out_data is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| opd_a | input | 512 | First operand (truth-table index bit 2) |
| opd_b | input | 512 | Second operand (index bit 1) |
| opd_c | input | 512 | Third operand (index bit 0) |
| func_code | input | 8 | Truth table of the three-input function |
| lane_wide | input | 1 | 1: 64-bit lanes, 0: 32-bit lanes |
| lane_mask | input | 16 | Per-lane write enable |
| merge_en | input | 1 | 1: masked-off lanes take pass_src, 0: they read zero |
| pass_src | input | 512 | Source for masked-off lanes in merge mode |
| out_valid | output | 1 | out_data holds a new result |
| out_data | output | 512 | Registered masked result |

## Verification
Most internal faults appear on the first result after the faulty inputs, one clock after in_valid. Three kinds of fault are expected:
- A wrong truth-table index order flips bits under codes that are not symmetric in their inputs, such as select.
- A wrong lane-to-mask mapping corrupts whole 32-bit or 64-bit lanes at once, and only in one lane mode.
- A wrong fill in masked-off lanes shows as zeros where pass-through data was due, or the reverse.

A register that reloads while idle shows as an output that changes during cycles with in_valid low.

// File: rtl/tvl_pkg.sv
package tvl_pkg;
   localparam int unsigned TT_W    = 8;
   localparam int unsigned TT_IDXW = 3;
   typedef logic [TT_W-1:0] tt_code_t;

   typedef enum int unsigned {
      EVAL_INDEX   = 0,
      EVAL_DECODE  = 1
   } eval_style_e;
endpackage

// File: rtl/tvl_truth_eval.sv
module tvl_truth_eval
   import tvl_pkg::*;
#(
   parameter int unsigned VEC_W = 512,
   parameter int unsigned STYLE = EVAL_INDEX
) (
   input  logic [VEC_W-1:0] a_i,
   input  logic [VEC_W-1:0] b_i,
   input  logic [VEC_W-1:0] c_i,
   input  tt_code_t         code_i,
   output logic [VEC_W-1:0] y_o
);
   if (VEC_W == 0) begin : g_bad_width
      $error("tvl_truth_eval: VEC_W must be nonzero");
   end
   if (STYLE != EVAL_INDEX && STYLE != EVAL_DECODE) begin : g_bad_style
      $error("tvl_truth_eval: unknown STYLE");
   end

   for (genvar i = 0; i < VEC_W; i++) begin : g_bit
      logic [TT_IDXW-1:0] idx;
      assign idx = {a_i[i], b_i[i], c_i[i]};
      if (STYLE == EVAL_INDEX) begin : g_mux
         assign y_o[i] = code_i[idx];
      end else begin : g_dec
         tt_code_t onehot;
         assign onehot = tt_code_t'(1) << idx;
         assign y_o[i] = |(code_i & onehot);
      end
   end
endmodule

// File: rtl/tvl_lane_enable.sv
module tvl_lane_enable #(
   parameter int unsigned VEC_W       = 512,
   parameter int unsigned WIDE_LANE   = 64,
   parameter int unsigned NARROW_LANE = 32,
   parameter int unsigned MASK_W      = 16
) (
   input  logic              lane_wide_i,
   input  logic [MASK_W-1:0] mask_i,
   output logic [VEC_W-1:0]  bit_en_o
);
   localparam int unsigned NARROW_CNT = VEC_W / NARROW_LANE;
   localparam int unsigned WIDE_CNT   = VEC_W / WIDE_LANE;
   localparam int unsigned RATIO      = WIDE_LANE / NARROW_LANE;

   if (VEC_W % WIDE_LANE != 0 || WIDE_LANE % NARROW_LANE != 0) begin : g_bad_geom
      $error("tvl_lane_enable: lane sizes must divide the vector evenly");
   end
   if (MASK_W != NARROW_CNT || WIDE_CNT > MASK_W) begin : g_bad_mask
      $error("tvl_lane_enable: MASK_W must equal the narrow lane count");
   end

   for (genvar j = 0; j < NARROW_CNT; j++) begin : g_lane
      logic en;
      assign en = lane_wide_i ? mask_i[j / RATIO] : mask_i[j];
      assign bit_en_o[j*NARROW_LANE +: NARROW_LANE] = {NARROW_LANE{en}};
   end
endmodule

// File: rtl/tvl_writeback.sv
module tvl_writeback #(
   parameter int unsigned VEC_W = 512
) (
   input  logic [VEC_W-1:0] result_i,
   input  logic [VEC_W-1:0] pass_i,
   input  logic [VEC_W-1:0] bit_en_i,
   input  logic             merge_i,
   output logic [VEC_W-1:0] data_o
);
   logic [VEC_W-1:0] fill;
   assign fill   = merge_i ? pass_i : '0;
   assign data_o = (result_i & bit_en_i) | (fill & ~bit_en_i);
endmodule

// File: rtl/tvl_top.sv
module tvl_top
   import tvl_pkg::*;
#(
   parameter int unsigned VEC_W       = 512,
   parameter int unsigned WIDE_LANE   = 64,
   parameter int unsigned NARROW_LANE = 32,
   parameter int unsigned MASK_W      = VEC_W / NARROW_LANE,
   parameter int unsigned EVAL_STYLE  = EVAL_INDEX
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [VEC_W-1:0]  opd_a,
   input  logic [VEC_W-1:0]  opd_b,
   input  logic [VEC_W-1:0]  opd_c,
   input  logic [TT_W-1:0]   func_code,
   input  logic              lane_wide,
   input  logic [MASK_W-1:0] lane_mask,
   input  logic              merge_en,
   input  logic [VEC_W-1:0]  pass_src,
   output logic              out_valid,
   output logic [VEC_W-1:0]  out_data
);
   localparam int unsigned WIDE_CNT = VEC_W / WIDE_LANE;

   logic [VEC_W-1:0] func_res;
   logic [VEC_W-1:0] bit_en;
   logic [VEC_W-1:0] next_data;

   tvl_truth_eval #(.VEC_W(VEC_W), .STYLE(EVAL_STYLE)) u_eval (
      .a_i    (opd_a),
      .b_i    (opd_b),
      .c_i    (opd_c),
      .code_i (func_code),
      .y_o    (func_res)
   );

   tvl_lane_enable #(
      .VEC_W(VEC_W), .WIDE_LANE(WIDE_LANE),
      .NARROW_LANE(NARROW_LANE), .MASK_W(MASK_W)
   ) u_lane_en (
      .lane_wide_i (lane_wide),
      .mask_i      (lane_mask),
      .bit_en_o    (bit_en)
   );

   tvl_writeback #(.VEC_W(VEC_W)) u_wb (
      .result_i (func_res),
      .pass_i   (pass_src),
      .bit_en_i (bit_en),
      .merge_i  (merge_en),
      .data_o   (next_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= next_data;
         end
      end
   end

   // R9: valid trails input by one clock; data holds while idle
   a_r9_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r9_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));
   // R6: zeroing of a masked-off wide lane
   a_r6_zero_lane0: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane_wide && !merge_en && !lane_mask[0])
      |=> out_data[WIDE_LANE-1:0] == '0);
   // R7: merging of a masked-off narrow lane
   a_r7_merge_lane0: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !lane_wide && merge_en && !lane_mask[0])
      |=> out_data[NARROW_LANE-1:0] == $past(pass_src[NARROW_LANE-1:0]));
   // R2: parity code with full mask
   a_r2_parity: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && func_code == 8'h96 && (&lane_mask))
      |=> out_data == $past(opd_a ^ opd_b ^ opd_c));
   // R3: constant-one code with full wide mask
   a_r3_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && func_code == 8'hFF && lane_wide && (&lane_mask[WIDE_CNT-1:0]))
      |=> out_data == {VEC_W{1'b1}});
endmodule

// File: tb/tvl_top_bench.sv
module tvl_top_bench;
   localparam int VW = 512;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [VW-1:0] opd_a = '0, opd_b = '0, opd_c = '0, pass_src = '0;
   logic [7:0]    func_code = '0;
   logic          lane_wide = 1'b0;
   logic [15:0]   lane_mask = '0;
   logic          merge_en = 1'b0;
   logic          out_valid;
   logic [VW-1:0] out_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [VW-1:0] data;
      string         tag;
   } exp_t;
   exp_t          sb[$];
   logic [VW-1:0] last_exp = '0;

   always #4 clk = ~clk;

   tvl_top u_tvl_top (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .opd_a(opd_a), .opd_b(opd_b), .opd_c(opd_c),
      .func_code(func_code), .lane_wide(lane_wide), .lane_mask(lane_mask),
      .merge_en(merge_en), .pass_src(pass_src),
      .out_valid(out_valid), .out_data(out_data)
   );

   function automatic logic [VW-1:0] rnd();
      logic [VW-1:0] v;
      for (int k = 0; k < VW/32; k++) v[k*32 +: 32] = $urandom();
      return v;
   endfunction

   // Expected value from the requirements: truth-table index {a,b,c},
   // lane index = bit/64 or bit/32, mask-off fill zero or pass_src.
   function automatic logic [VW-1:0] model(
      input logic [VW-1:0] a, b, c, input logic [7:0] code,
      input logic wide, input logic [15:0] m, input logic mrg,
      input logic [VW-1:0] ps);
      logic [VW-1:0] r;
      for (int i = 0; i < VW; i++) begin
         int idx;
         int lane;
         idx  = int'(a[i]) * 4 + int'(b[i]) * 2 + int'(c[i]);
         lane = wide ? i / 64 : i / 32;
         if (m[lane]) r[i] = code[idx];
         else         r[i] = mrg ? ps[i] : 1'b0;
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [VW-1:0] act,
                        input logic [VW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input string tag, input logic [VW-1:0] a, b, c,
                        input logic [7:0] code, input logic wide,
                        input logic [15:0] m, input logic mrg,
                        input logic [VW-1:0] ps, input logic [VW-1:0] exp);
      exp_t e;
      @(negedge clk);
      opd_a = a; opd_b = b; opd_c = c; func_code = code;
      lane_wide = wide; lane_mask = m; merge_en = mrg; pass_src = ps;
      in_valid = 1'b1;
      e.data = exp;
      e.tag  = tag;
      sb.push_back(e);
      last_exp = exp;
   endtask

   task automatic drive_m(input string tag, input logic [7:0] code,
                          input logic wide, input logic [15:0] m,
                          input logic mrg);
      logic [VW-1:0] a, b, c, ps;
      a = rnd(); b = rnd(); c = rnd(); ps = rnd();
      drive(tag, a, b, c, code, wide, m, mrg, ps,
            model(a, b, c, code, wide, m, mrg, ps));
   endtask

   // monitor: pops one expected item per valid result
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb.size() == 0) begin
            checks++; fails++;
            $display("FAIL R9: result with no pending item, actual %h expected none", out_data);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, out_data, e.data);
         end
      end
   end

   initial begin
      logic [VW-1:0] a, b, c, ps;
      repeat (3) @(negedge clk);
      // R10 reset state
      checks++; if (out_valid !== 1'b0) begin fails++; $display("FAIL R10: out_valid actual %b expected 0", out_valid); end
      check("R10 reset data", out_data, '0);
      rst_n = 1'b1;

      // R1 random codes, full mask
      for (int n = 0; n < 16; n++) drive_m("R1 random code", 8'($urandom()), n[0], 16'hFFFF, n[1]);

      // R2 named codes against closed forms
      a = rnd(); b = rnd(); c = rnd(); ps = rnd();
      drive("R2 xor3",   a, b, c, 8'h96, 1'b1, 16'hFFFF, 1'b0, ps, a ^ b ^ c);
      drive("R2 major",  a, b, c, 8'hE8, 1'b0, 16'hFFFF, 1'b0, ps, (a & b) | (a & c) | (b & c));
      drive("R2 select", a, b, c, 8'hCA, 1'b1, 16'hFFFF, 1'b1, ps, (a & b) | (~a & c));
      drive("R2 and3",   a, b, c, 8'h80, 1'b0, 16'hFFFF, 1'b1, ps, a & b & c);
      // R3 constants, or, nor
      drive("R3 zero",   a, b, c, 8'h00, 1'b1, 16'hFFFF, 1'b0, ps, '0);
      drive("R3 ones",   a, b, c, 8'hFF, 1'b1, 16'h00FF, 1'b0, ps, '1);
      drive("R3 or3",    a, b, c, 8'hFE, 1'b0, 16'hFFFF, 1'b0, ps, a | b | c);
      drive("R3 nor3",   a, b, c, 8'h01, 1'b0, 16'hFFFF, 1'b1, ps, ~(a | b | c));

      // R4 wide lanes; upper mask bits must not matter
      drive_m("R4 wide mask A5", 8'hCA, 1'b1, 16'h00A5, 1'b0);
      drive_m("R4 wide upper ignored", 8'hE8, 1'b1, 16'hFF5A, 1'b1);
      a = rnd(); b = rnd(); c = rnd(); ps = rnd();
      drive("R4 wide upper only", a, b, c, 8'hFF, 1'b1, 16'hFF00, 1'b0, ps, '0);
      // R5 narrow lanes
      drive_m("R5 narrow zero", 8'h96, 1'b0, 16'h6C39, 1'b0);
      drive_m("R5 narrow merge", 8'hD8, 1'b0, 16'h93C6, 1'b1);
      // R6 / R7 masked-off lanes
      a = rnd(); b = rnd(); c = rnd(); ps = rnd();
      drive("R6 all off zero", a, b, c, 8'hFF, 1'b0, 16'h0000, 1'b0, ps, '0);
      drive("R7 all off merge", a, b, c, 8'hFF, 1'b1, 16'h0000, 1'b1, ps, ps);
      // R8 full mask ignores mode
      drive("R8 full mask merge", a, b, c, 8'h17, 1'b0, 16'hFFFF, 1'b1, ps,
            (a & ~(b | c)) | (~a & ~(b & c) & (b | c)) | (~a & ~b & ~c));
      drive("R8 full wide mask zero", a, b, c, 8'h28, 1'b1, 16'h00FF, 1'b0, ps, c & (a ^ b));

      // R9 idle: valid drops, data holds despite changing inputs
      @(negedge clk);
      in_valid = 1'b0;
      for (int n = 0; n < 3; n++) begin
         @(negedge clk);
         opd_a = rnd(); func_code = 8'($urandom()); lane_mask = 16'($urandom());
      end
      checks++;
      if (out_valid !== 1'b0) begin fails++; $display("FAIL R9: idle out_valid actual %b expected 0", out_valid); end
      check("R9 hold while idle", out_data, last_exp);
      if (sb.size() != 0) begin
         checks++; fails++;
         $display("FAIL R9: pending items actual %0d expected 0", sb.size());
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule